// File: doc/BRIEF.md
# Checksum-Extended Parallel Matrix Multiplier

This block multiplies two N×N unsigned integer matrices and returns a product of size (N+1)×(N+1) that carries its own checksums. The left operand gains an extra bottom row holding its column totals. The right operand gains an extra right-hand column holding its row totals. The extra row and column of the product can then be compared downstream to detect a faulty lane and to find which one it is.

One multiply-accumulate lane exists per output column, N+1 in all, and every lane works in the same cycle. The block reads whole operand rows from a row-wide memory with a one-cycle read latency. The left operand's row i is stored at address i, and the right operand's row k is stored at address N+k. Element j of a row occupies bits [j*D +: D].

The block first reads every right-operand row once to precompute its row totals. After that it latches one left-operand row at a time and streams the right-operand rows past all lanes. The left-operand column totals are gathered as its rows go by, and they form the final output row. Each finished output row is written as one word. A per-lane fault-injection input lets a test force an accumulator bit high.

Top module: `chk_matmul`

## Requirements
- R1: Element N (the last column) of output row i, for i < N, equals the sum mod 2^D of the N data elements of that row.
- R2: Output row N, elements 0..N-1, equals the column-wise sums mod 2^D of output rows 0..N-1.
- R3: Output element (i,j) for i,j < N equals the sum over k of A[i][k]·B[k][j], taken mod 2^D. A is read from addresses 0..N-1 and B from addresses N..2N-1, with element j at bits [j*D +: D].
- R4: The corner element (N,N) equals the mod-2^D sum of the row-N data elements, and it also equals the mod-2^D sum of column N over rows 0..N-1.
- R5: Each run writes exactly N+1 output rows, at addresses 0,1,…,N in ascending order. Writes are never on adjacent cycles, and element j of the write word is at bits [j*D +: D].
- R6: `done` is high for exactly one cycle, and that cycle comes directly after the write to address N.
- R7: While reset is held, and in the first cycle after reset, `wr_en`, `rd_en` and `done` are low.
- R8: When `inj_lane[j]` is set, lane j's accumulator is cleared to 0 at the start of each output row. On each of its N accumulate steps it becomes (acc + a·b) mod 2^D with bit `inj_bit` forced to 1. The written element is the value after the last step.
- R9: A `start` pulse that arrives while a run is in progress has no effect. The current results are unchanged, and no extra rows are written.
- R10: Each run starts its checksums from zero, so a run begun straight after another produces results that depend only on its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (sampled only while idle) |
| rd_en | output | 1 | Operand memory read request |
| rd_addr | output | $clog2(2N) | Operand memory row address |
| rd_data | input | N·D | Row returned one cycle after `rd_en` |
| wr_en | output | 1 | Output row write strobe |
| wr_addr | output | $clog2(N+1) | Output row index |
| wr_data | output | (N+1)·D | Output row, element j at bits [j*D +: D] |
| done | output | 1 | One-cycle end-of-run pulse |
| inj_lane | input | N+1 | Per-lane stuck-at-one injection enable |
| inj_bit | input | $clog2(D) | Accumulator bit forced by injection |

## Verification
A wrong stored row total would show up only in column N. A column total that was never cleared or was mis-added would show up only in row N. A mis-cleared or misfed lane would corrupt its whole column. Each of these defects therefore has its own footprint at the write port, and it appears at the first output row that uses the bad state, which is one row-time (N+3 cycles) after the left row is latched. The scoreboard compares every element of every written row. It also compares the row address and the timing of `done`, so a write that is missing, extra or out of order is reported as soon as the next write or `done` appears.

// File: rtl/mm_pkg.sv
// Shared types for the checksum-extended matrix multiplier.
// Assumes: nothing beyond the standard.
package mm_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_PRE, S_LOADA, S_MUL, S_DRAIN, S_WRITE, S_DONE
    } mm_state_e;

    // What the row arriving from memory this cycle is for
    typedef enum logic [1:0] {
        K_NONE, K_BSUM, K_ALOAD, K_MULT
    } mm_kind_e;
endpackage

// File: rtl/mm_bsum.sv
// Right-operand row totals: adds all elements of an arriving row and
// stores the total in one of N slots; one slot is read combinationally.
// Assumes: wr_idx and rd_idx are below N.
module mm_bsum #(
    parameter int N  = 3,
    parameter int D  = 16,
    parameter int IW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic [IW-1:0]  wr_idx,
    input  logic [N*D-1:0] row,
    input  logic [IW-1:0]  rd_idx,
    output logic [D-1:0]   sum
);
    logic [D-1:0] slot [N];
    logic [D-1:0] total;

    // Sum the row's elements modulo 2^D
    always_comb begin
        total = '0;
        for (int k = 0; k < N; k++) total = total + row[k*D +: D];
    end

    // Store the total into its slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) slot[k] <= '0;
        end else if (wr) begin
            slot[wr_idx] <= total;
        end
    end

    assign sum = slot[rd_idx];

    p_sum_idx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (int'(wr_idx) < N));
endmodule

// File: rtl/mm_asum.sv
// Left-operand row buffer and running column totals. A loaded row is
// latched and added into the totals; use_sum copies the totals into the
// buffer to form the checksum row.
// Assumes: load and use_sum are never high together; sel is below N.
module mm_asum #(
    parameter int N  = 3,
    parameter int D  = 16,
    parameter int IW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           load,
    input  logic           use_sum,
    input  logic [N*D-1:0] row,
    input  logic [IW-1:0]  sel,
    output logic [D-1:0]   elem
);
    logic [D-1:0] abuf [N];
    logic [D-1:0] csum [N];

    // Column totals: cleared per run, accumulated per loaded row
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int k = 0; k < N; k++) csum[k] <= '0;
        end else if (load) begin
            for (int k = 0; k < N; k++) csum[k] <= csum[k] + row[k*D +: D];
        end
    end

    // Row buffer: real row, or the totals for the final row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) abuf[k] <= '0;
        end else if (load) begin
            for (int k = 0; k < N; k++) abuf[k] <= row[k*D +: D];
        end else if (use_sum) begin
            for (int k = 0; k < N; k++) abuf[k] <= csum[k];
        end
    end

    assign elem = abuf[sel];

    p_load_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && use_sum));
    p_clr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && load));
endmodule

// File: rtl/mm_lane.sv
// One multiply-accumulate lane: clear, then add a*b mod 2^D per step.
// An optional injection forces one accumulator bit high on every step.
// Assumes: clr and step are not high together.
module mm_lane #(
    parameter int D  = 16,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [D-1:0]  a,
    input  logic [D-1:0]  b,
    input  logic          inj,
    input  logic [BW-1:0] inj_bit,
    output logic [D-1:0]  acc
);
    logic [2*D-1:0] prod;
    logic [D-1:0]   force_mask;

    // Full product and the stuck-at-one mask
    always_comb begin
        prod       = a * b;
        force_mask = inj ? (D'(1) << inj_bit) : '0;
    end

    // Accumulator register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc <= '0;
        else if (step)     acc <= (acc + prod[D-1:0]) | force_mask;
    end

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));
    p_stuck_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && inj && !clr) |=> acc[$past(inj_bit)]);
endmodule

// File: rtl/chk_matmul.sv
// Checksum-extended matrix multiplier top: sequences the row-total
// pre-pass, the per-row left-operand load, the streaming of right rows
// to N+1 lanes, and one output write per row.
// Assumes: operand memory returns rd_data one cycle after rd_en.
module chk_matmul
    import mm_pkg::*;
#(
    parameter int N = 3,
    parameter int D = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    output logic                   rd_en,
    output logic [$clog2(2*N)-1:0] rd_addr,
    input  logic [N*D-1:0]         rd_data,
    output logic                   wr_en,
    output logic [$clog2(N+1)-1:0] wr_addr,
    output logic [(N+1)*D-1:0]     wr_data,
    output logic                   done,
    input  logic [N:0]             inj_lane,
    input  logic [$clog2(D)-1:0]   inj_bit
);
    localparam int AW = $clog2(2*N);
    localparam int RW = $clog2(N+1);
    localparam int BW = $clog2(D);
    localparam int L  = N + 1;

    mm_state_e    st;
    mm_kind_e     issue_kind, pk;
    logic [RW-1:0] cnt, row, pidx;
    logic [D-1:0]  a_elem, bsum_q;
    logic          last_cnt;

    assign last_cnt = (cnt == RW'(N-1));

    // Read request and its purpose for the current state
    always_comb begin
        rd_en      = 1'b0;
        rd_addr    = '0;
        issue_kind = K_NONE;
        case (st)
            S_PRE: begin
                rd_en = 1'b1; rd_addr = AW'(N) + AW'(cnt); issue_kind = K_BSUM;
            end
            S_MUL: begin
                rd_en = 1'b1; rd_addr = AW'(N) + AW'(cnt); issue_kind = K_MULT;
            end
            S_LOADA: if (row != RW'(N)) begin
                rd_en = 1'b1; rd_addr = AW'(row); issue_kind = K_ALOAD;
            end
            default: ;
        endcase
    end

    // Track what the returning row is for and which index it carries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pk   <= K_NONE;
            pidx <= '0;
        end else begin
            pk   <= issue_kind;
            pidx <= cnt;
        end
    end

    // Run sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; cnt <= '0; row <= '0;
        end else begin
            case (st)
                S_IDLE:  if (start) begin st <= S_PRE; cnt <= '0; end
                S_PRE:   if (last_cnt) begin st <= S_LOADA; cnt <= '0; row <= '0; end
                         else cnt <= cnt + 1'b1;
                S_LOADA: begin st <= S_MUL; cnt <= '0; end
                S_MUL:   if (last_cnt) st <= S_DRAIN; else cnt <= cnt + 1'b1;
                S_DRAIN: st <= S_WRITE;
                S_WRITE: if (row == RW'(N)) st <= S_DONE;
                         else begin row <= row + 1'b1; st <= S_LOADA; end
                default: st <= S_IDLE;
            endcase
        end
    end

    mm_bsum #(.N(N), .D(D), .IW(RW)) u_bsum (
        .clk(clk), .rst_n(rst_n), .wr(pk == K_BSUM), .wr_idx(pidx),
        .row(rd_data), .rd_idx(pidx), .sum(bsum_q)
    );

    mm_asum #(.N(N), .D(D), .IW(RW)) u_asum (
        .clk(clk), .rst_n(rst_n), .clr((st == S_IDLE) && start),
        .load(pk == K_ALOAD), .use_sum((st == S_LOADA) && (row == RW'(N))),
        .row(rd_data), .sel(pidx), .elem(a_elem)
    );

    for (genvar j = 0; j < L; j++) begin : g_lane
        logic [D-1:0] b_in, acc;
        if (j < N) begin : g_data
            assign b_in = rd_data[j*D +: D];
        end else begin : g_check
            assign b_in = bsum_q;
        end
        mm_lane #(.D(D), .BW(BW)) u_lane (
            .clk(clk), .rst_n(rst_n), .clr(st == S_LOADA), .step(pk == K_MULT),
            .a(a_elem), .b(b_in), .inj(inj_lane[j]), .inj_bit(inj_bit), .acc(acc)
        );
        assign wr_data[j*D +: D] = acc;
    end

    assign wr_en   = (st == S_WRITE);
    assign wr_addr = row;
    assign done    = (st == S_DONE);

    p_wr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) <= N));
    p_wr_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == RW'(N))) |=> done);
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_rd_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (int'(rd_addr) < 2*N));
endmodule

// File: tb/chk_matmul_test.sv
module chk_matmul_test;
    localparam int N  = 3;
    localparam int D  = 16;
    localparam int L  = N + 1;
    localparam int AW = $clog2(2*N);
    localparam int RW = $clog2(N+1);
    localparam int BW = $clog2(D);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic rd_en, wr_en, done;
    logic [AW-1:0] rd_addr;
    logic [N*D-1:0] rd_data = '0;
    logic [RW-1:0] wr_addr;
    logic [L*D-1:0] wr_data;
    logic [N:0] inj_lane = '0;
    logic [BW-1:0] inj_bit = '0;

    always #4 clk = ~clk;   // 125 MHz

    chk_matmul #(.N(N), .D(D)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .inj_lane(inj_lane), .inj_bit(inj_bit)
    );

    logic [N*D-1:0] mem [2*N];
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    logic [D-1:0] Av [N][N];
    logic [D-1:0] Bv [N][N];
    int checks = 0, fails = 0, done_cnt = 0;
    string rtag = "";
    logic [L*D-1:0] exp_row_q [$];
    int exp_addr_q [$];
    logic prev_final = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Driver side: expected rows from the requirement model
    task automatic push_expected(input logic [N:0] lanes, input logic [BW-1:0] bn);
        logic [D-1:0] ap [L][N];
        logic [D-1:0] bp [N][L];
        logic [D-1:0] acc, m;
        logic [L*D-1:0] r;
        for (int k = 0; k < N; k++) begin
            ap[N][k] = '0;
            bp[k][N] = '0;
        end
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                ap[i][k] = Av[i][k];
                ap[N][k] = ap[N][k] + Av[i][k];
                bp[i][k] = Bv[i][k];
                bp[i][N] = bp[i][N] + Bv[i][k];
            end
        for (int i = 0; i < L; i++) begin
            for (int j = 0; j < L; j++) begin
                m = lanes[j] ? (D'(1) << bn) : '0;
                acc = '0;
                for (int k = 0; k < N; k++) acc = (acc + ap[i][k] * bp[k][j]) | m;
                r[j*D +: D] = acc;
            end
            exp_row_q.push_back(r);
            exp_addr_q.push_back(i);
        end
    endtask

    task automatic run(input string tag, input logic [N:0] lanes,
                       input logic [BW-1:0] bn, input bit poke);
        int d0;
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                mem[i][k*D +: D]   = Av[i][k];
                mem[N+i][k*D +: D] = Bv[i][k];
            end
        rtag = tag;
        push_expected(lanes, bn);
        @(negedge clk);
        inj_lane = lanes; inj_bit = bn;
        d0 = done_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin   // R9: start while busy
            repeat (6) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(exp_row_q.size() == 0, poke ? "R9" : "R5", "rows left unwritten",
            exp_row_q.size(), 0);
        exp_row_q.delete(); exp_addr_q.delete();
        inj_lane = '0;
    endtask

    // Monitor: compare writes and done timing
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_final || done)
                chk(done && prev_final, "R6", "done after last write", done, prev_final);
            if (done) done_cnt++;
            if (wr_en) begin
                if (exp_row_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected write", wr_addr, 0);
                end else begin
                    logic [L*D-1:0] er;
                    int ea;
                    er = exp_row_q.pop_front();
                    ea = exp_addr_q.pop_front();
                    chk(int'(wr_addr) == ea, "R5", "row address", wr_addr, ea);
                    for (int j = 0; j < L; j++) begin
                        string t;
                        if (rtag != "")                  t = rtag;
                        else if (ea == N && j == N)      t = "R4";
                        else if (ea == N)                t = "R2";
                        else if (j == N)                 t = "R1";
                        else                             t = "R3";
                        chk(wr_data[j*D +: D] == er[j*D +: D], t,
                            $sformatf("row %0d col %0d", ea, j),
                            wr_data[j*D +: D], er[j*D +: D]);
                    end
                end
            end
            prev_final = wr_en && (int'(wr_addr) == N);
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R6", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!wr_en && !rd_en && !done, "R7", "outputs in reset",
            {wr_en, rd_en, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_en && !rd_en && !done, "R7", "outputs after reset",
            {wr_en, rd_en, done}, 0);

        // Small known product embedded in the corner
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin Av[i][k] = '0; Bv[i][k] = '0; end
        Av[0][0] = 1; Av[0][1] = 2; Av[1][0] = 3; Av[1][1] = 4;
        Bv[0][0] = 5; Bv[0][1] = 6; Bv[1][0] = 7; Bv[1][1] = 8;
        run("", '0, '0, 1'b0);

        // Sequential values
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                Av[i][k] = D'(i*N + k + 1);
                Bv[i][k] = D'((i+2)*(k+1) + 3);
            end
        run("", '0, '0, 1'b0);

        // All-ones values: wrap of products and sums
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin Av[i][k] = '1; Bv[i][k] = '1; end
        run("", '0, '0, 1'b0);

        // R10: back-to-back run with fresh operands
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                Av[i][k] = D'(7*i + 3*k + 250);
                Bv[i][k] = D'(1000*k + 11*i + 9);
            end
        run("R10", '0, '0, 1'b0);

        // R8: stuck bit 0 in data lane 1
        run("R8", (N+1)'(2), BW'(0), 1'b0);

        // R8: stuck top bit in checksum lane, with a start poke (R9)
        run("R8", (N+1)'(1) << N, BW'(D-1), 1'b1);

        // R9: plain run with start poke mid-run
        run("", '0, '0, 1'b1);

        finish_run();
    end
endmodule